// File: doc/BRIEF.md
# Three-Stage Handshaked Increment Pipeline

This block runs an 8-bit unsigned value through three processing stages in series. Each stage adds one, so a value leaves the chain three higher than it entered, and the sum wraps modulo 256. Each stage needs several clock cycles for its work. The first takes 2 cycles, the second 3 and the third 5. Neighbouring stages pass values over a valid/ready handshake. A finished stage keeps its result until the next stage takes it.

A stage can hand its result downstream and take a new value from upstream in the same cycle. Because of this, a continuous input stream with a consumer that is always ready leaves the chain once every 5 cycles, the period of the slowest stage. It does not leave once per clock. When the consumer stalls, backpressure travels upstream stage by stage. The chain then holds at most three values and stops taking input. Each stage's free flag is brought out so that the fill state can be seen.

Top module: `step_chain`

## Requirements
- R1: Every value delivered on `out_data` equals the value accepted on `in_data` plus three.
- R2: The addition wraps modulo 256, so inputs 253, 254 and 255 come out as 0, 1 and 2.
- R3: With an empty chain and a ready consumer, a value presented in cycle k with `in_ready` high appears with `out_valid` high in cycle k+10.
- R4: With continuous input and `out_ready` held high, successive output handshakes are exactly 5 cycles apart. Under any stimulus, no two output handshakes are closer than 5 cycles.
- R5: An input value is sampled only in a cycle where `in_valid` and `in_ready` are both high. `in_taken` is high in exactly those cycles. In the cycle after an acceptance, the first stage is not free.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable in the next cycle.
- R7: Results leave in acceptance order, with none lost or duplicated. The number of outputs never exceeds the number of accepted inputs.
- R8: While reset is high and in the first cycle after it, `out_valid` is low, `in_ready` is high and `stage_free` is 3'b111. Values in flight at reset are discarded.
- R9: Bit i of `stage_free` (bit 0 is the first stage) is high only when stage i is idle, or when its held result is being taken in that cycle. With a stalled consumer, the chain holds at most three values. One value held at the last stage gives 3'b011, and three held values give 3'b000 with `in_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers `in_data` |
| in_data | input | W (8) | Value to process |
| in_ready | output | 1 | First stage can take a value this cycle |
| in_taken | output | 1 | Value is sampled at the coming edge |
| out_valid | output | 1 | Last stage holds a finished result |
| out_data | output | W (8) | Finished result |
| out_ready | input | 1 | Consumer takes `out_data` this cycle |
| stage_free | output | 3 | Per-stage free flag, bit 0 is the first stage |

## Verification
The assertions check on every cycle that a stalled output is held steady and that output handshakes keep at least the last stage's period apart. They also check that the chain never delivers more values than it accepted or holds more than three, that an accepted value occupies the first stage, and that reset leaves everything empty. Only the bench scenarios can show the 10-cycle latency, the exact 5-cycle spacing under a steady stream, and the correct plus-three values with wrap-around across all 256 inputs. Order under irregular stalls and the fill patterns of `stage_free` also need the bench scenarios.

// File: rtl/chain_pkg.sv
package chain_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  // Life cycle of one stage: waiting for work, counting, holding a result
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WORK = 2'd1,
    ST_HOLD = 2'd2
  } stage_state_e;

  // Latency of stage idx, chosen from the three top-level parameters
  function automatic int pick_lat(input int idx, input int lat_a, input int lat_b, input int lat_c);
    case (idx)
      0:       return lat_a;
      1:       return lat_b;
      default: return lat_c;
    endcase
  endfunction

endpackage

// File: rtl/lat_timer.sv
module lat_timer #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic last
);
  timeunit 1ns;
  timeprecision 100ps;

  // The cycle of acceptance counts as the first work cycle
  localparam int LOADV = (LAT >= 2) ? LAT - 2 : 0;
  localparam int CW    = (LOADV > 1) ? $clog2(LOADV + 1) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(LOADV);
    end else if (tick && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/incr_stage.sv
module incr_stage #(
  parameter int W   = 8,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  timeunit 1ns;
  timeprecision 100ps;
  import chain_pkg::*;

  // The arithmetic of one stage: add one, wrapping at 2**W
  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  stage_state_e st;
  logic [W-1:0] res_q;
  logic         take_evt;   // upstream value sampled at this edge
  logic         give_evt;   // held result taken downstream at this edge
  logic         tmr_last;

  assign give_evt  = (st == ST_HOLD) && out_ready;
  assign in_ready  = (st == ST_IDLE) || give_evt;
  assign take_evt  = in_valid && in_ready;
  assign out_valid = (st == ST_HOLD);
  assign out_data  = res_q;

  lat_timer #(.LAT(LAT)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (take_evt),
    .tick (st == ST_WORK),
    .last (tmr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      res_q <= '0;
    end else if (take_evt) begin
      res_q <= bump(in_data);
      st    <= (LAT <= 1) ? ST_HOLD : ST_WORK;
    end else begin
      case (st)
        ST_WORK: if (tmr_last) st <= ST_HOLD;
        ST_HOLD: if (give_evt) st <= ST_IDLE;
        default: st <= st;
      endcase
    end
  end

endmodule

// File: rtl/step_chain.sv
module step_chain #(
  parameter int W     = 8,
  parameter int LAT_A = 2,
  parameter int LAT_B = 3,
  parameter int LAT_C = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         in_taken,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  output logic [2:0]   stage_free
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NSTAGE = 3;

  // Link k joins stage k-1 to stage k; link 0 is the input, link NSTAGE the output
  logic [NSTAGE:0]        lv;
  logic [NSTAGE:0]        lr;
  logic [NSTAGE:0][W-1:0] ld;

  assign lv[0]      = in_valid;
  assign ld[0]      = in_data;
  assign lr[NSTAGE] = out_ready;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    incr_stage #(
      .W   (W),
      .LAT (chain_pkg::pick_lat(g, LAT_A, LAT_B, LAT_C))
    ) u_stage (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (lv[g]),
      .in_data   (ld[g]),
      .in_ready  (lr[g]),
      .out_valid (lv[g+1]),
      .out_data  (ld[g+1]),
      .out_ready (lr[g+1])
    );
  end

  assign in_ready   = lr[0];
  assign in_taken   = in_valid && lr[0];
  assign out_valid  = lv[NSTAGE];
  assign out_data   = ld[NSTAGE];
  assign stage_free = lr[NSTAGE-1:0];

endmodule

// File: rtl/chain_chk.sv
module chain_chk #(
  parameter int W      = 8,
  parameter int NSTAGE = 3,
  parameter int LAT_A  = 2,
  parameter int LAT_C  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_taken,
  input logic              out_valid,
  input logic              out_ready,
  input logic [W-1:0]      out_data,
  input logic [NSTAGE-1:0] stage_free
);
  timeunit 1ns;
  timeprecision 100ps;

  logic in_fire, out_fire;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  // Values inside the chain, counted from the handshakes
  logic [7:0] pend;
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else if (in_fire && !out_fire) pend <= pend + 8'd1;
    else if (out_fire && !in_fire) pend <= pend - 8'd1;
  end

  // Cycles since the last output handshake, saturating at LAT_C
  int  gap;
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (out_fire) begin
      gap  <= 1;
      seen <= 1'b1;
    end else if (gap < LAT_C) begin
      gap  <= gap + 1;
    end
  end

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4
  out_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (out_fire && seen) |-> (gap >= LAT_C));

  // R7
  no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
    out_fire |-> (pend != 8'd0));

  // R9
  fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
    pend <= 8'(NSTAGE));

  // R5
  take_occupies_chk: assert property (@(posedge clk) disable iff (rst)
    (LAT_A > 1 && in_taken) |=> !stage_free[0]);

  // R8
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && in_ready && stage_free == '1));

endmodule

bind step_chain chain_chk #(
  .W      (W),
  .NSTAGE (NSTAGE),
  .LAT_A  (LAT_A),
  .LAT_C  (LAT_C)
) u_chain_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_taken   (in_taken),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .stage_free (stage_free)
);

// File: tb/test_step_chain.sv
module test_step_chain;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       out_ready = 1'b0;
  logic       in_ready, in_taken, out_valid;
  logic [7:0] out_data;
  logic [2:0] stage_free;

  step_chain i_step_chain (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .in_taken   (in_taken),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .stage_free (stage_free)
  );

  always #2.5 clk = ~clk;

  int         checks = 0;
  int         fails = 0;
  int         cyc = 0;
  int         last_out = -1;
  int         lat_in = -1;
  int         lat_out = -1;
  bit         gap_exact = 1'b0;
  bit         stall_mode = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  logic [7:0] expq[$];
  logic [7:0] e;
  logic [7:0] held;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: drives the stall pattern at the falling edge, samples 1 ns later
  always @(negedge clk) begin
    cyc++;
    if (stall_mode) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[3];
    end
    #1;
    if (rst) begin
      expq.delete();
      last_out = -1;
    end else begin
      if (in_valid && in_ready) begin
        expq.push_back(in_data + 8'd3);
        if (lat_in < 0) lat_in = cyc;
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R7 extra output", int'(out_data), -1);
        end else begin
          e = expq.pop_front();
          if (e < 8'd3) check(out_data == e, "R2 wrap value", int'(out_data), int'(e));
          else          check(out_data == e, "R1/R7 value", int'(out_data), int'(e));
        end
        if (last_out >= 0) begin
          if (gap_exact) check(cyc - last_out == 5, "R4 exact spacing", cyc - last_out, 5);
          else           check(cyc - last_out >= 5, "R4 min spacing", cyc - last_out, 5);
        end
        last_out = cyc;
        if (lat_out < 0) lat_out = cyc;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    out_ready = 1'b1;
    tick(3);
    #1;
    // R8 state during reset
    check(!out_valid, "R8 out_valid in reset", int'(out_valid), 0);
    check(in_ready, "R8 in_ready in reset", int'(in_ready), 1);
    check(stage_free == 3'b111, "R8 stage_free in reset", int'(stage_free), 7);
    @(negedge clk) rst = 1'b0;
    tick(2);

    // R5: data without in_valid is never sampled
    in_data = 8'h40;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      #1;
      check(!out_valid && !in_taken, "R5 invalid input ignored", int'(out_valid), 0);
    end

    // R3: latency through an empty chain
    lat_in = -1;
    lat_out = -1;
    send(8'd7);
    idle();
    tick(14);
    check(lat_out - lat_in == 10, "R3 latency", lat_out - lat_in, 10);

    // R6 and R9: one value held at the last stage
    @(negedge clk) out_ready = 1'b0;
    send(8'd20);
    idle();
    tick(12);
    #1;
    check(out_valid, "R6 result held", int'(out_valid), 1);
    check(stage_free == 3'b011, "R9 single held value", int'(stage_free), 3);
    held = out_data;
    tick(3);
    #1;
    check(out_valid && out_data == held, "R6 stable while stalled", int'(out_data), int'(held));
    @(negedge clk) out_ready = 1'b1;
    tick(3);

    // R9 and R5: fill the chain with the consumer stalled
    @(negedge clk) out_ready = 1'b0;
    send(8'd100);
    send(8'd101);
    send(8'd102);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'd103;
    tick(25);
    #1;
    check(!in_ready, "R9 full chain refuses input", int'(in_ready), 0);
    check(!in_taken, "R5 no sample while not ready", int'(in_taken), 0);
    check(stage_free == 3'b000, "R9 all stages occupied", int'(stage_free), 0);
    check(out_valid && out_data == 8'd103, "R6 oldest value at output", int'(out_data), 103);
    @(negedge clk) out_ready = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    idle();
    tick(40);
    check(expq.size() == 0, "R7 drained after fill", expq.size(), 0);

    // R1, R2, R4: every input value in a continuous stream
    last_out = -1;
    gap_exact = 1'b1;
    for (int v = 0; v < 256; v++) send(8'(v));
    idle();
    tick(30);
    gap_exact = 1'b0;
    check(expq.size() == 0, "R7 drained after stream", expq.size(), 0);

    // R7: full sweep with an irregular consumer
    last_out = -1;
    stall_mode = 1'b1;
    for (int v = 0; v < 256; v++) send(8'(v) ^ 8'ha5);
    idle();
    stall_mode = 1'b0;
    @(negedge clk) out_ready = 1'b1;
    tick(40);
    check(expq.size() == 0, "R7 drained after stalled stream", expq.size(), 0);

    // R8: reset with values in flight
    send(8'd1);
    send(8'd2);
    idle();
    tick(3);
    @(negedge clk) rst = 1'b1;
    tick(2);
    #1;
    check(!out_valid, "R8 out_valid after mid-flight reset", int'(out_valid), 0);
    check(stage_free == 3'b111, "R8 stages freed", int'(stage_free), 7);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #1;
      check(!out_valid, "R8 no stale output", int'(out_valid), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule